// File: doc/BRIEF.md
# SDRAM Clock-Enable Suspend Controller

This block sits on the controller side of an SDRAM interface and owns the clock-enable pin while a read burst is in flight. A burst is opened with a one-cycle start pulse. From then on the block walks a position counter through the column-issue phase and the CAS-latency pipeline. It tells the rest of the controller when to advance the burst and when a returning data beat should be captured, and which beat that is.

A suspend request during a burst drives the clock enable low from the next cycle. This freezes the position counter, so no beat advances and none is captured. The frozen state holds until a release request arrives, and the burst then resumes at the beat where it stopped. If no release comes, the block ends the suspend by itself once a parameterised cycle cap is reached. That cap is chosen below the refresh interval, because the memory does not refresh itself while suspended. After any exit, the command-ready output stays low for a recovery interval, so that no new command reaches the memory too early.

All pins are plain control and status lines. There is no streaming data interface, so there are no back-pressure rules: the captured beat index is valid for exactly the cycle in which the capture strobe is high.

Top module: `cke_suspend_ctrl`

## Requirements
- R1: After reset the clock enable is 1, command-ready is 1, busy is 0, and advance, capture strobe and timeout are all 0.
- R2: A start pulse is accepted only while command-ready is 1. With a burst length of 4 and a CAS latency of 2, an unsuspended burst keeps busy high for 6 cycles starting on the cycle after acceptance. It raises advance in the first 4 of those cycles. It raises the capture strobe in the last 4, with the beat index counting 0, 1, 2, 3. A start pulse given while busy is ignored.
- R3: A suspend request is accepted only while busy is 1, the clock enable is 1 and the burst is not on its final cycle. When accepted, the clock enable reads 0 from the next cycle. A request at any other time leaves the clock enable at 1, and a request made while already suspended has no effect.
- R4: While the clock enable is 0, advance, capture strobe and command-ready are 0 and the beat index is held. After the exit the burst continues from the frozen position, so the burst still totals 6 active cycles and delivers each beat index exactly once, in order.
- R5: A release request during a suspended cycle returns the clock enable to 1 on the next cycle. A release request while not suspended has no effect.
- R6: If no release arrives, the clock enable goes back to 1 after MAX_SUSP consecutive low cycles (default 16). The timeout flag is then 1 for exactly the first cycle with the clock enable high. A released suspend never raises the timeout flag.
- R7: After any suspend exit, command-ready stays 0 for the first T_CKA cycles with the clock enable high (default 3), even if the burst has finished. It can be 1 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | Opens a read burst when command-ready is high |
| susp_req | input | 1 | Asks to suspend the running burst |
| susp_rel | input | 1 | Asks to end the current suspend |
| cke | output | 1 | Clock enable to the memory |
| busy | output | 1 | A burst is in progress |
| beat_adv | output | 1 | Burst column counter may advance this cycle |
| cap_valid | output | 1 | A data beat should be captured this cycle |
| cap_idx | output | IDX_W | Index of the beat being captured |
| cmd_ready | output | 1 | A new command may be issued |
| timeout | output | 1 | The last suspend was ended by the cycle cap |

## Verification
A scoreboard holds the beat indices each burst should deliver. It is fed bursts in four patterns: one that runs untouched, one suspended early and then released, one held until the cap forces the exit, and one suspended on its second-to-last cycle. The untouched and released bursts tell a correct freeze apart from a counter that keeps running or skips a beat while the clock enable is low. The capped burst separates a correctly sized limit from one that is one cycle short or one cycle long, and it checks the single-cycle timeout flag. The late suspend checks that recovery still holds command-ready low after the burst has ended. Stray requests on an idle block, a start pulse during a burst, and a request on the final cycle show that each is ignored.

// File: rtl/cks_pkg.sv
package cks_pkg;
  typedef enum logic [0:0] {
    SUSP_RUN  = 1'b0,
    SUSP_HELD = 1'b1
  } susp_state_t;

  function automatic int safe_clog2(input int v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/cks_burst_track.sv
module cks_burst_track #(
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int POS_W     = cks_pkg::safe_clog2(BURST_LEN + CAS_LAT),
  parameter int IDX_W     = cks_pkg::safe_clog2(BURST_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hold,
  output logic             busy,
  output logic             at_last,
  output logic             beat_adv,
  output logic             cap_valid,
  output logic [IDX_W-1:0] cap_idx
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BURST_LEN + CAS_LAT - 1);
  localparam logic [POS_W-1:0] CL_POS   = POS_W'(CAS_LAT);
  localparam logic [POS_W-1:0] BL_POS   = POS_W'(BURST_LEN);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] cap_off;
  logic             live;

  assign live = busy && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pos  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      pos  <= '0;
    end else if (live) begin
      if (pos == LAST_POS) begin
        busy <= 1'b0;
        pos  <= '0;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign cap_off   = pos - CL_POS;
  assign at_last   = busy && (pos == LAST_POS);
  assign beat_adv  = live && (pos < BL_POS);
  assign cap_valid = live && (pos >= CL_POS);
  assign cap_idx   = cap_off[IDX_W-1:0];
endmodule

// File: rtl/cks_susp_fsm.sv
module cks_susp_fsm #(
  parameter int MAX_SUSP = 16,
  parameter int SCNT_W   = cks_pkg::safe_clog2(MAX_SUSP)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic rel,
  input  logic busy,
  input  logic at_last,
  output logic held,
  output logic leaving,
  output logic timeout
);
  import cks_pkg::*;

  localparam logic [SCNT_W-1:0] CAP_CNT = SCNT_W'(MAX_SUSP - 1);

  susp_state_t      st;
  logic [SCNT_W-1:0] cnt;
  logic             forced;
  logic             accept;

  assign held    = (st == SUSP_HELD);
  assign accept  = (st == SUSP_RUN) && req && busy && !at_last;
  assign forced  = held && !rel && (cnt == CAP_CNT);
  assign leaving = held && (rel || (cnt == CAP_CNT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SUSP_RUN;
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= forced;
      case (st)
        SUSP_RUN: begin
          cnt <= '0;
          if (accept) st <= SUSP_HELD;
        end
        SUSP_HELD: begin
          if (leaving) begin
            st  <= SUSP_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SUSP_RUN;
      endcase
    end
  end
endmodule

// File: rtl/cks_recovery.sv
module cks_recovery #(
  parameter int T_CKA = 3,
  parameter int REC_W = cks_pkg::safe_clog2(T_CKA + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic pending
);
  logic [REC_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)          left <= '0;
    else if (load)       left <= REC_W'(T_CKA);
    else if (left != '0) left <= left - 1'b1;
  end

  assign pending = (left != '0);
endmodule

// File: rtl/cke_suspend_ctrl.sv
module cke_suspend_ctrl #(
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int MAX_SUSP  = 16,
  parameter int T_CKA     = 3,
  parameter int IDX_W     = cks_pkg::safe_clog2(BURST_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start,
  input  logic             susp_req,
  input  logic             susp_rel,
  output logic             cke,
  output logic             busy,
  output logic             beat_adv,
  output logic             cap_valid,
  output logic [IDX_W-1:0] cap_idx,
  output logic             cmd_ready,
  output logic             timeout
);
  logic held;
  logic leaving;
  logic at_last;
  logic rec_pending;
  logic start_ok;

  assign start_ok = burst_start && cmd_ready;

  cks_burst_track #(
    .BURST_LEN(BURST_LEN),
    .CAS_LAT  (CAS_LAT),
    .IDX_W    (IDX_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_ok),
    .hold     (held),
    .busy     (busy),
    .at_last  (at_last),
    .beat_adv (beat_adv),
    .cap_valid(cap_valid),
    .cap_idx  (cap_idx)
  );

  cks_susp_fsm #(
    .MAX_SUSP(MAX_SUSP)
  ) u_susp (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (susp_req),
    .rel    (susp_rel),
    .busy   (busy),
    .at_last(at_last),
    .held   (held),
    .leaving(leaving),
    .timeout(timeout)
  );

  cks_recovery #(
    .T_CKA(T_CKA)
  ) u_rec (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (leaving),
    .pending(rec_pending)
  );

  assign cke       = !held;
  assign cmd_ready = !busy && !held && !rec_pending;
endmodule

// File: rtl/cke_suspend_ctrl_chk.sv
module cke_suspend_ctrl_chk #(
  parameter int MAX_SUSP = 16,
  parameter int IDX_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             susp_req,
  input logic             susp_rel,
  input logic             cke,
  input logic             busy,
  input logic             beat_adv,
  input logic             cap_valid,
  input logic [IDX_W-1:0] cap_idx,
  input logic             cmd_ready,
  input logic             timeout
);
  localparam int RUN_W = $clog2(MAX_SUSP + 1);
  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                         low_run <= '0;
    else if (cke)                       low_run <= '0;
    else if (low_run != RUN_W'(MAX_SUSP)) low_run <= low_run + 1'b1;
  end

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (cke && !busy));

  p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(busy && susp_req));

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!beat_adv && !cap_valid && !cmd_ready));

  p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> $stable(cap_idx));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && susp_rel) |=> cke);

  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (low_run < RUN_W'(MAX_SUSP)));

  p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (cke && $past(!cke) && !$past(susp_rel)));

  p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !cmd_ready);
endmodule

bind cke_suspend_ctrl cke_suspend_ctrl_chk #(
  .MAX_SUSP(MAX_SUSP),
  .IDX_W   (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .susp_req (susp_req),
  .susp_rel (susp_rel),
  .cke      (cke),
  .busy     (busy),
  .beat_adv (beat_adv),
  .cap_valid(cap_valid),
  .cap_idx  (cap_idx),
  .cmd_ready(cmd_ready),
  .timeout  (timeout)
);

// File: tb/cke_suspend_ctrl_tb.sv
module cke_suspend_ctrl_tb;
  localparam int BL = 4;
  localparam int CL = 2;
  localparam int MAXS = 16;
  localparam int TCKA = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_start = 1'b0;
  logic susp_req = 1'b0;
  logic susp_rel = 1'b0;
  logic cke, busy, beat_adv, cap_valid, cmd_ready, timeout;
  logic [IW-1:0] cap_idx;

  int total = 0;
  int bad = 0;
  int q[$];

  always #10 clk = ~clk;

  cke_suspend_ctrl #(.BURST_LEN(BL), .CAS_LAT(CL), .MAX_SUSP(MAXS), .T_CKA(TCKA)) u_dut (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .susp_req(susp_req),
    .susp_rel(susp_rel), .cke(cke), .busy(busy), .beat_adv(beat_adv),
    .cap_valid(cap_valid), .cap_idx(cap_idx), .cmd_ready(cmd_ready), .timeout(timeout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: open a burst and queue the beats it should deliver
  task automatic start_burst();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    burst_start = 1'b1;
    for (int i = 0; i < BL; i++) q.push_back(i);
    @(negedge clk);
    burst_start = 1'b0;
  endtask

  // monitor: compare each captured beat with the scoreboard
  always @(negedge clk) begin
    if (rst_n && cap_valid) begin
      if (q.size() == 0) chk("R4 unexpected beat", int'(cap_idx), -1);
      else chk("R2/R4 beat index", int'(cap_idx), q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    int adv;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 cke", cke, 1);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 busy", busy, 0);
    chk("R1 beat_adv", beat_adv, 0);
    chk("R1 cap_valid", cap_valid, 0);
    chk("R1 timeout", timeout, 0);

    // R3 / R5: requests on an idle block are ignored
    susp_req = 1'b1; step(1); susp_req = 1'b0; step(1);
    chk("R3 idle request cke", cke, 1);
    susp_rel = 1'b1; step(1); susp_rel = 1'b0; step(1);
    chk("R5 idle release cke", cke, 1);
    chk("R5 idle release ready", cmd_ready, 1);

    // R2: plain burst with a stray start pulse mid-burst
    start_burst();
    chk("R2 busy", busy, 1);
    chk("R2 ready low", cmd_ready, 0);
    cnt = 0; adv = 0;
    while (busy && cnt < 50) begin
      cnt++;
      burst_start = (cnt == 1);
      if (beat_adv) adv++;
      step(1);
    end
    burst_start = 1'b0;
    chk("R2 busy cycles", cnt, BL + CL);
    chk("R2 advance cycles", adv, BL);
    chk("R2 beats drained", q.size(), 0);

    // R3/R4/R5: suspend at position 1, release after a hold
    start_burst();
    step(1);
    susp_req = 1'b1; step(1); susp_req = 1'b0;
    chk("R3 cke low", cke, 0);
    for (int i = 0; i < 5; i++) begin
      susp_req = (i == 2);
      chk("R4 frozen adv", beat_adv, 0);
      chk("R4 frozen cap", cap_valid, 0);
      chk("R4 frozen ready", cmd_ready, 0);
      step(1);
    end
    susp_req = 1'b0;
    chk("R3 repeat request cke", cke, 0);
    susp_rel = 1'b1; step(1); susp_rel = 1'b0;
    chk("R5 cke back", cke, 1);
    chk("R4 resume adv", beat_adv, 1);
    chk("R6 no timeout on release", timeout, 0);
    cnt = 0;
    while (busy && cnt < 50) begin cnt++; step(1); end
    chk("R4 remaining active cycles", cnt, 4);

    // R6: timeout-forced exit
    start_burst();
    susp_req = 1'b1; step(1); susp_req = 1'b0;
    cnt = 0;
    while (!cke && cnt < 100) begin cnt++; step(1); end
    chk("R6 low cycles", cnt, MAXS);
    chk("R6 timeout flag", timeout, 1);
    chk("R7 ready after timeout", cmd_ready, 0);
    step(1);
    chk("R6 timeout single", timeout, 0);
    cnt = 0;
    while (busy && cnt < 50) begin cnt++; step(1); end

    // R7: suspend on second-to-last cycle, recovery outlives the burst
    start_burst();
    step(4);
    susp_req = 1'b1; step(1); susp_req = 1'b0;
    chk("R3 late cke low", cke, 0);
    step(2);
    susp_rel = 1'b1; step(1); susp_rel = 1'b0;
    for (int i = 0; i < TCKA; i++) begin
      chk("R7 recovery ready low", cmd_ready, 0);
      step(1);
    end
    chk("R7 ready after recovery", cmd_ready, 1);
    chk("R7 burst over", busy, 0);

    // R3: request on final cycle is ignored
    start_burst();
    step(5);
    susp_req = 1'b1; step(1); susp_req = 1'b0;
    chk("R3 last-cycle request cke", cke, 1);
    chk("R3 last-cycle busy", busy, 0);
    chk("R3 last-cycle ready", cmd_ready, 1);

    step(4);
    chk("R4 all beats delivered", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule